// File: doc/BRIEF.md
# Command-Macro Sequencer Core

This block is the control core of a small command-macro engine. A program of 32-bit instruction words sits in a local instruction memory, and one pulse on `start` runs it. The program works on a queue of 32-bit input parameters that arrive on a valid/ready stream. The core keeps a byte-addressed program counter and eight 32-bit general registers. Register 0 always reads as zero. The core decodes each word, reads the source operands, forms the result and writes it back. Every executed instruction appears on a trace port: its address, its destination index and its result.

Control flow has two features with a delay slot. The first is a conditional branch that tests one register for zero or for nonzero. When the branch is taken, the next sequential instruction still runs before the jump, unless the annul bit is set; with annul set, the jump happens at once. The second is an exit flag, which lets one more instruction run before the run stops. If that exit instruction sits in a branch delay slot, the instruction that runs after it is the one at the branch target.

At the end of a run, the core raises an error in two cases: a branch was taken inside a delay slot, or the number of parameters consumed differs from the count given at start.

Top module: `msq_core`

## Requirements
- R1: When `start` is accepted in idle, the core clears all registers and the program counter. It takes the first parameter into register 1, and that parameter counts as consumed. The first instruction then runs at address 0.
- R2: The program counter holds a byte address. It advances by 4 for each instruction that runs, and the word it fetches is memory index pc/4. Instruction fields: bit 31 is exit, bits 30:28 are the opcode (0 add two registers, 1 add signed immediate, 2 fetch a parameter into dst, 3 branch if zero, 4 branch if nonzero, others do nothing), bit 27 is annul, bits 26:24 are dst, bits 23:21 are srcA, bits 20:18 are srcB, and bits 17:0 are a signed immediate.
- R3: Register 0 reads as zero. A write to it is discarded.
- R4: A taken branch jumps to the branch's own address plus the immediate times 4. The immediate may be negative.
- R5: A taken branch with annul clear runs the next sequential instruction, then continues at the target.
- R6: A taken branch with annul set goes to the target at once, and the instruction after the branch does not run.
- R7: Opcode 3 is taken when srcA equals zero, and opcode 4 when srcA is nonzero. A branch that is not taken continues at address+4.
- R8: An instruction with the exit bit set is followed by exactly one more instruction, and then the run ends.
- R9: An exit that sits in a branch delay slot is followed by the instruction at the branch target, and then the run ends.
- R10: A taken branch inside any delay slot ends the run at once and sets `err_slot`.
- R11: At the end of a run, `err_count` is set when the number of parameters consumed differs from `param_total`.
- R12: A fetch instruction waits while `param_valid` is low. `param_ready` is high only while waiting in load or on a fetch, and no instruction is executed during the wait.
- R13: `busy` is high from the cycle after `start` is accepted until the end of the run. `done` is a one-cycle pulse, and the error flags hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_we | input | 1 | Instruction memory write strobe |
| load_addr | input | 5 | Instruction memory word index |
| load_data | input | 32 | Instruction word to store |
| start | input | 1 | Start a run (taken only when idle) |
| param_total | input | 8 | Number of parameters supplied for this run |
| param_valid | input | 1 | Parameter stream valid |
| param_data | input | 32 | Parameter stream data |
| param_ready | output | 1 | Core takes the parameter this cycle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err_slot | output | 1 | Branch taken inside a delay slot |
| err_count | output | 1 | Parameter count mismatch |
| exec_valid | output | 1 | An instruction executes this cycle |
| exec_pc | output | 7 | Byte address of the executing instruction |
| exec_dst | output | 3 | Destination register index |
| exec_result | output | 32 | Value written to the destination |

## Verification
The assertions assume that `start` is not held high across the end of a run. They also assume the instruction memory is not written while `busy` is high, so the word fetched at a given address stays the same for the whole run. The bench loads every program word before it pulses `start` and releases `start` after one cycle. It drives `param_valid` only from its own gap counter, and it sweeps branch condition, annul, operand value and target offset over every combination in a small window. The trace is then compared against the address sequence worked out arithmetically.

// File: rtl/msq_pkg.sv
package msq_pkg;
  localparam int RFW = 3;
  localparam int IMMW = 18;

  localparam logic [2:0] OP_ADD   = 3'd0;
  localparam logic [2:0] OP_ADDI  = 3'd1;
  localparam logic [2:0] OP_FETCH = 3'd2;
  localparam logic [2:0] OP_BZ    = 3'd3;
  localparam logic [2:0] OP_BNZ   = 3'd4;

  typedef struct packed {
    logic            ex;
    logic [2:0]      op;
    logic            annul;
    logic [RFW-1:0]  dst;
    logic [RFW-1:0]  sa;
    logic [RFW-1:0]  sb;
    logic [IMMW-1:0] imm;
  } instr_t;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RUN, S_FIN} state_t;
endpackage

// File: rtl/msq_imem.sv
module msq_imem #(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/msq_regfile.sv
module msq_regfile #(
  parameter int NREG = 8,
  parameter int DW   = 32,
  localparam int RIW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           we,
  input  logic [RIW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [RIW-1:0] ra_addr,
  output logic [DW-1:0]  ra_data,
  input  logic [RIW-1:0] rb_addr,
  output logic [DW-1:0]  rb_data
);
  logic [NREG-1:0][DW-1:0] rv;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign rv[i] = '0;
    end else begin : g_flop
      logic [DW-1:0] q;
      logic          en;
      logic [DW-1:0] d;
      assign en = clr | (we & (waddr == RIW'(i)));
      assign d  = clr ? '0 : wdata;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= d;
      end
      assign rv[i] = q;
    end
  end

  assign ra_data = rv[ra_addr];
  assign rb_data = rv[rb_addr];
endmodule

// File: rtl/msq_decode.sv
module msq_decode
  import msq_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] word,
  output instr_t        ins,
  output logic          is_branch,
  output logic          is_fetch,
  output logic          writes_reg,
  output logic [DW-1:0] imm_sext
);
  assign ins        = instr_t'(word[31:0]);
  assign is_branch  = (ins.op == OP_BZ) | (ins.op == OP_BNZ);
  assign is_fetch   = (ins.op == OP_FETCH);
  assign writes_reg = (ins.op == OP_ADD) | (ins.op == OP_ADDI) | is_fetch;
  assign imm_sext   = {{(DW-IMMW){ins.imm[IMMW-1]}}, ins.imm};
endmodule

// File: rtl/msq_core.sv
module msq_core
  import msq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  parameter int NREG  = 8,
  parameter int CW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int PCW  = AW + 2,
  localparam int RIW  = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_we,
  input  logic [AW-1:0]  load_addr,
  input  logic [DW-1:0]  load_data,
  input  logic           start,
  input  logic [CW-1:0]  param_total,
  input  logic           param_valid,
  input  logic [DW-1:0]  param_data,
  output logic           param_ready,
  output logic           busy,
  output logic           done,
  output logic           err_slot,
  output logic           err_count,
  output logic           exec_valid,
  output logic [PCW-1:0] exec_pc,
  output logic [RIW-1:0] exec_dst,
  output logic [DW-1:0]  exec_result
);
  state_t         state_q, state_d;
  logic [PCW-1:0] pc_q, pc_d;
  logic [PCW-1:0] tgt_q, tgt_d;
  logic           br_pend_q, br_pend_d;
  logic           ex_pend_q, ex_pend_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [CW-1:0]  tot_q, tot_d;
  logic           eslot_q, eslot_d;
  logic           ecnt_q, ecnt_d;

  logic [DW-1:0]  word;
  instr_t         ins;
  logic           is_branch, is_fetch, writes_reg;
  logic [DW-1:0]  imm_sext;
  logic [DW-1:0]  ra, rb;
  logic           run, in_slot, br_taken, slot_fault, accept;
  logic [PCW-1:0] br_target, pc_inc;
  logic [DW-1:0]  result;
  logic           rf_we, rf_clr;
  logic [RIW-1:0] rf_waddr;
  logic [DW-1:0]  rf_wdata;

  msq_imem #(.DEPTH(DEPTH), .DW(DW)) u_imem (
    .clk(clk), .we(load_we), .waddr(load_addr), .wdata(load_data),
    .raddr(pc_q[PCW-1:2]), .rdata(word)
  );

  msq_decode #(.DW(DW)) u_dec (
    .word(word), .ins(ins), .is_branch(is_branch), .is_fetch(is_fetch),
    .writes_reg(writes_reg), .imm_sext(imm_sext)
  );

  msq_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk(clk), .rst_n(rst_n), .clr(rf_clr), .we(rf_we), .waddr(rf_waddr),
    .wdata(rf_wdata), .ra_addr(ins.sa[RIW-1:0]), .ra_data(ra),
    .rb_addr(ins.sb[RIW-1:0]), .rb_data(rb)
  );

  // execute-stage control
  assign run        = (state_q == S_RUN);
  assign accept     = (state_q == S_IDLE) & start;
  assign in_slot    = br_pend_q | ex_pend_q;
  assign exec_valid = run & (~is_fetch | param_valid);
  assign br_taken   = is_branch & ((ins.op == OP_BZ) ? (ra == '0) : (ra != '0));
  assign slot_fault = exec_valid & br_taken & in_slot;
  assign pc_inc     = pc_q + PCW'(4);
  assign br_target  = pc_q + {ins.imm[PCW-3:0], 2'b00};
  assign param_ready = (state_q == S_LOAD) | (run & is_fetch);

  always_comb begin
    case (ins.op)
      OP_ADD:   result = ra + rb;
      OP_ADDI:  result = ra + imm_sext;
      OP_FETCH: result = param_data;
      default:  result = '0;
    endcase
  end

  // register-file write port: parameter load in S_LOAD, writeback in S_RUN
  always_comb begin
    rf_clr   = accept;
    rf_we    = 1'b0;
    rf_waddr = ins.dst[RIW-1:0];
    rf_wdata = result;
    if (state_q == S_LOAD) begin
      rf_we    = param_valid;
      rf_waddr = RIW'(1);
      rf_wdata = param_data;
    end else if (exec_valid & writes_reg & ~slot_fault) begin
      rf_we = 1'b1;
    end
  end

  // next-state logic
  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;
    tgt_d     = tgt_q;
    br_pend_d = br_pend_q;
    ex_pend_d = ex_pend_q;
    cnt_d     = cnt_q;
    tot_d     = tot_q;
    eslot_d   = eslot_q;
    ecnt_d    = ecnt_q;
    unique case (state_q)
      S_IDLE: begin
        if (start) begin
          state_d   = S_LOAD;
          pc_d      = '0;
          br_pend_d = 1'b0;
          ex_pend_d = 1'b0;
          cnt_d     = '0;
          tot_d     = param_total;
          eslot_d   = 1'b0;
          ecnt_d    = 1'b0;
        end
      end
      S_LOAD: begin
        if (param_valid) begin
          cnt_d   = CW'(1);
          state_d = S_RUN;
        end
      end
      S_RUN: begin
        if (exec_valid) begin
          if (is_fetch) cnt_d = cnt_q + CW'(1);
          br_pend_d = 1'b0;
          if (slot_fault) begin
            eslot_d = 1'b1;
            state_d = S_FIN;
          end else if (ex_pend_q) begin
            state_d = S_FIN;
          end else begin
            ex_pend_d = ins.ex;
            if (br_taken && ins.annul) begin
              pc_d = br_target;
            end else if (br_taken) begin
              pc_d      = pc_inc;
              br_pend_d = 1'b1;
              tgt_d     = br_target;
            end else begin
              pc_d = br_pend_q ? tgt_q : pc_inc;
            end
          end
          if (state_d == S_FIN) ecnt_d = (cnt_d != tot_q);
        end
      end
      S_FIN: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      pc_q      <= '0;
      tgt_q     <= '0;
      br_pend_q <= 1'b0;
      ex_pend_q <= 1'b0;
      cnt_q     <= '0;
      tot_q     <= '0;
      eslot_q   <= 1'b0;
      ecnt_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      pc_q      <= pc_d;
      tgt_q     <= tgt_d;
      br_pend_q <= br_pend_d;
      ex_pend_q <= ex_pend_d;
      cnt_q     <= cnt_d;
      tot_q     <= tot_d;
      eslot_q   <= eslot_d;
      ecnt_q    <= ecnt_d;
    end
  end

  assign busy        = (state_q == S_LOAD) | run;
  assign done        = (state_q == S_FIN);
  assign err_slot    = eslot_q;
  assign err_count   = ecnt_q;
  assign exec_pc     = pc_q;
  assign exec_dst    = ins.dst[RIW-1:0];
  assign exec_result = result;
endmodule

// File: rtl/msq_core_checker.sv
module msq_core_checker #(
  parameter int PCW = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic           param_ready,
  input logic           param_valid,
  input logic           exec_valid,
  input logic           err_slot,
  input logic           taken,
  input logic           annul,
  input logic           in_slot,
  input logic           ex_pend,
  input logic [PCW-1:0] pc,
  input logic [PCW-1:0] target
);
  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_start_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done) |=> busy);

  assert_stall_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (param_ready && !param_valid) |-> !exec_valid);

  assert_ready_in_run_R12: assert property (@(posedge clk) disable iff (!rst_n)
    param_ready |-> busy);

  assert_annul_jump_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && taken && annul && !in_slot) |=> (pc == $past(target)));

  assert_slot_branch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && taken && in_slot) |=> (done && err_slot));

  assert_exit_slot_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && ex_pend) |=> done);
endmodule

bind msq_core msq_core_checker #(.PCW(PCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .param_ready(param_ready), .param_valid(param_valid), .exec_valid(exec_valid),
  .err_slot(err_slot), .taken(br_taken), .annul(ins.annul), .in_slot(in_slot),
  .ex_pend(ex_pend_q), .pc(pc_q), .target(br_target)
);

// File: tb/msq_core_bench.sv
module msq_core_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_we = 1'b0;
  logic [4:0]  load_addr = '0;
  logic [31:0] load_data = '0;
  logic        start = 1'b0;
  logic [7:0]  param_total = '0;
  logic        param_valid = 1'b0;
  logic [31:0] param_data = '0;
  logic        param_ready, busy, done, err_slot, err_count, exec_valid;
  logic [6:0]  exec_pc;
  logic [2:0]  exec_dst;
  logic [31:0] exec_result;

  always #(PERIOD/2) clk = ~clk;

  msq_core u_msq_core (.*);

  int errors = 0;
  int checks = 0;

  int pv [8];
  int np, gap;
  int tr_pc [64];
  int tr_res [64];
  int ntr, waitc, stall_bad, busy_bad, pulse_bad;
  logic got_eslot, got_ecnt;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int ex, input int op, input int an,
                                     input int d, input int sa, input int sb, input int imm);
    logic [31:0] w;
    w = {ex[0], op[2:0], an[0], d[2:0], sa[2:0], sb[2:0], imm[17:0]};
    return w;
  endfunction

  task automatic ld(input int a, input logic [31:0] w);
    @(negedge clk);
    load_we = 1'b1; load_addr = a[4:0]; load_data = w;
    @(negedge clk);
    load_we = 1'b0;
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 32; i++) ld(i, mk(0, 1, 0, 0, 0, 0, 0));
  endtask

  task automatic do_run(input int total);
    int pidx, gc, cyc;
    pidx = 0; gc = gap; cyc = 0;
    ntr = 0; waitc = 0; stall_bad = 0; busy_bad = 0; pulse_bad = 0;
    @(negedge clk);
    start = 1'b1; param_total = total[7:0];
    @(negedge clk);
    start = 1'b0;
    forever begin
      param_valid = (gc == 0) && (pidx < np);
      param_data  = (pidx < np) ? pv[pidx] : 0;
      #1;
      if (done) break;
      if (!busy) busy_bad++;
      if (exec_valid && ntr < 64) begin
        tr_pc[ntr] = exec_pc; tr_res[ntr] = exec_result; ntr++;
      end
      if (param_ready && !param_valid) begin
        waitc++;
        if (exec_valid) stall_bad++;
      end
      if (param_ready && param_valid) begin
        pidx++; gc = gap;
      end else if (gc > 0) gc--;
      cyc++;
      if (cyc > 2000) begin
        chk(0, "R13 run timeout", cyc, 0);
        break;
      end
      @(negedge clk);
    end
    got_eslot = err_slot; got_ecnt = err_count;
    if (busy) busy_bad++;
    param_valid = 1'b0;
    @(negedge clk);
    #1;
    if (done) pulse_bad++;
    chk(busy_bad == 0, "R13 busy span", busy_bad, 0);
    chk(pulse_bad == 0, "R13 done one cycle", pulse_bad, 0);
    chk(err_slot == got_eslot && err_count == got_ecnt, "R13 error flags hold",
        {err_slot, err_count}, {got_eslot, got_ecnt});
  endtask

  task automatic cmp_pcs(input string req, input int exp [], input int n);
    chk(ntr == n, req, ntr, n);
    for (int i = 0; i < n && i < ntr; i++) chk(tr_pc[i] == exp[i], req, tr_pc[i], exp[i]);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int e [];
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !done && !param_ready && !exec_valid && !err_slot && !err_count,
        "R13 reset state", {busy, done, param_ready, exec_valid, err_slot, err_count}, 0);
    rst_n = 1'b1;

    // Basic program: R1, R2, R3, R8, R11, R12
    clear_prog();
    ld(0, mk(0, 1, 0, 2, 1, 0, 0));
    ld(1, mk(0, 1, 0, 0, 1, 0, 7));
    ld(2, mk(0, 0, 0, 3, 0, 2, 0));
    ld(3, mk(0, 2, 0, 4, 0, 0, 0));
    ld(4, mk(0, 0, 0, 5, 4, 3, 0));
    ld(5, mk(1, 1, 0, 6, 7, 0, 3));
    ld(6, mk(0, 1, 0, 7, 1, 0, 0));
    pv[0] = 11; pv[1] = 22; np = 2;
    for (int run = 0; run < 3; run++) begin
      gap = (run == 1) ? 6 : 0;
      do_run(run == 2 ? 3 : 2);
      e = '{0, 4, 8, 12, 16, 20, 24};
      cmp_pcs("R2 sequential trace", e, 7);
      e = '{11, 18, 11, 22, 33, 3, 11};
      for (int i = 0; i < 7 && i < ntr; i++) chk(tr_res[i] == e[i], "R1 R3 result", tr_res[i], e[i]);
      chk(ntr > 5 && tr_res[5] == 3, "R1 register cleared at start", tr_res[5], 3);
      chk(got_eslot == 0, "R10 no slot error", got_eslot, 0);
      chk(got_ecnt == (run == 2), "R11 count check", got_ecnt, run == 2);
      chk(stall_bad == 0, "R12 no execute while waiting", stall_bad, 0);
      if (run == 1) chk(waitc >= 6, "R12 waits for parameter", waitc, 6);
    end

    // Branch sweep: R4, R5, R6, R7, R8
    clear_prog();
    ld(0, mk(0, 1, 0, 2, 1, 0, 0));
    ld(2, mk(0, 1, 0, 3, 0, 0, 100));
    for (int a = 3; a < 16; a++) ld(a, mk(1, 1, 0, 5, 0, 0, a));
    np = 1; gap = 0;
    for (int cond = 3; cond <= 4; cond++)
      for (int an = 0; an < 2; an++)
        for (int pz = 0; pz < 2; pz++)
          for (int k = 2; k <= 5; k++) begin
            int p, t, n;
            bit tk;
            int ex [];
            p = pz ? 5 : 0;
            pv[0] = p;
            ld(1, mk(0, cond, an, 0, 2, 0, k));
            do_run(1);
            tk = (cond == 3) ? (p == 0) : (p != 0);
            t = 4 + 4 * k;
            if (!tk)      begin ex = '{0, 4, 8, 12, 16}; n = 5; end
            else if (an)  begin ex = '{0, 4, t, t + 4};  n = 4; end
            else          begin ex = '{0, 4, 8, t, t + 4}; n = 5; end
            cmp_pcs(!tk ? "R7 not taken" : (an ? "R6 annul" : "R5 delay slot"), ex, n);
            if (ntr == n) chk(tr_res[n-1] == ex[n-1] / 4, "R8 exit slot result",
                              tr_res[n-1], ex[n-1] / 4);
          end

    // Negative offset loop: R4
    clear_prog();
    ld(0, mk(0, 1, 0, 2, 0, 0, 3));
    ld(1, mk(0, 1, 0, 2, 2, 0, -1));
    ld(2, mk(0, 4, 1, 0, 2, 0, -1));
    ld(3, mk(1, 1, 0, 3, 2, 0, 0));
    pv[0] = 9; np = 1;
    do_run(1);
    e = '{0, 4, 8, 4, 8, 4, 8, 12, 16};
    cmp_pcs("R4 backward branch", e, 9);
    if (ntr == 9) chk(tr_res[7] == 0, "R4 loop count", tr_res[7], 0);

    // Exit in branch delay slot: R9
    clear_prog();
    ld(0, mk(0, 4, 0, 0, 1, 0, 4));
    ld(1, mk(1, 1, 0, 2, 0, 0, 1));
    ld(2, mk(0, 1, 0, 3, 0, 0, 2));
    ld(4, mk(0, 1, 0, 4, 0, 0, 3));
    ld(5, mk(0, 1, 0, 5, 0, 0, 4));
    pv[0] = 1;
    do_run(1);
    e = '{0, 4, 16};
    cmp_pcs("R9 exit in branch slot", e, 3);
    if (ntr == 3) chk(tr_res[2] == 3, "R9 target result", tr_res[2], 3);

    // Branch inside delay slot: R10
    clear_prog();
    ld(0, mk(0, 4, 0, 0, 1, 0, 3));
    ld(1, mk(0, 3, 0, 0, 0, 0, 1));
    do_run(1);
    e = '{0, 4};
    cmp_pcs("R10 run ends at fault", e, 2);
    chk(got_eslot == 1, "R10 slot error flag", got_eslot, 1);
    chk(got_ecnt == 0, "R11 count ok on fault", got_ecnt, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule